// File: doc/BRIEF.md
# Column-Counting Array Multiplier

This block multiplies two unsigned 8-bit operands and returns their 16-bit product. All the single-bit partial products are formed at once with AND gates. Each weight column (the bits whose row and column indices add to the same value) is then summed in one step by a single multi-input ones-counter. The counter sizes match the column heights, so the tallest column of eight bits uses an 8-input, 4-bit counter and a seven-bit column uses a 7-input, 3-bit counter.

In the second stage each count bit of weight 2^m from column k is placed in column k+m. The shifted count words are then merged by one carry-propagate addition into the product. The operand width is a parameter, and the default is 8.

A parameter enables an output register. When it is on, an input strobe marked valid is captured on the next rising clock edge together with its product. When it is off, the product and the valid flag pass straight through.

Top module: `vcm_mul`

## Requirements
- R1: With the register enabled, `product` equals `op_a * op_b` (both read as unsigned binary numbers) one clock after a cycle in which `in_valid` is 1, for every one of the 65536 operand pairs.
- R2: Product bit 0 always equals `op_a[0] & op_b[0]`.
- R3: Column k (k = 0..14) holds min(k+1, 15-k) partial products and is summed by one counter whose count never exceeds that height. With both operands at 255 every column is full, and the product is 65025.
- R4: The count bit of weight 2^m from column k is added into column k+m. Any weight at or above bit 16 is discarded, and for unsigned operands it is always zero.
- R5: If either operand is 0, the product is 0.
- R6: If either operand is 1, the product equals the other operand.
- R7: `out_valid` is 1 exactly one clock after a cycle with `in_valid` = 1. After a cycle with `in_valid` = 0, `out_valid` is 0 and `product` keeps its previous value.
- R8: While `rst_n` is 0, `out_valid` and `product` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks the operands as a request to be captured |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | Product register holds a fresh result |
| product | output | 16 | Unsigned 16-bit product |

## Verification
The bench runs every operand pair back to back and compares each result with an arithmetic product it computes itself. This catches a partial product sent to the wrong column or a count bit injected at the wrong weight, because either fault corrupts a whole family of pairs. The all-ones pair fills every column, so a counter that is too narrow, or a dropped top carry, shows up as a wrong value near 65025. Zero and unit operands are checked separately, and so is product bit 0. A register that loads without a strobe is caught because the product changes during an idle cycle. A valid flag on the wrong cycle is caught as a missing or extra `out_valid`.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  // Number of partial products whose indices sum to column k.
  function automatic int col_height(input int k, input int w);
    return (k < w) ? k + 1 : 2 * w - 1 - k;
  endfunction

  // Lowest multiplicand row index that feeds column k.
  function automatic int col_first_row(input int k, input int w);
    return (k < w) ? 0 : k - w + 1;
  endfunction

  // Reference product, kept as plain arithmetic.
  function automatic longint unsigned ref_mul(input longint unsigned a,
                                              input longint unsigned b);
    return a * b;
  endfunction

endpackage

// File: rtl/pp_grid.sv
module pp_grid #(
  parameter int W = 8
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [W*W-1:0] pp
);
  // pp[i*W+j] = op_a[i] & op_b[j]; every term is formed in parallel.
  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_col
      assign pp[i*W+j] = op_a[i] & op_b[j];
    end
  end
endmodule

// File: rtl/ones_counter.sv
module ones_counter #(
  parameter int N  = 7,
  parameter int OW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [OW-1:0] count
);
  always_comb begin
    count = '0;
    for (int t = 0; t < N; t++) begin
      count = count + OW'(bits[t]);
    end
  end

  // The count of a column can never exceed its height.
  always_comb begin
    assert_count_le_height_R3: assert (int'(count) <= N);
  end
endmodule

// File: rtl/weight_merge.sv
module weight_merge #(
  parameter int W    = 8,
  parameter int CW   = 4,
  parameter int NCOL = 2 * W - 1
) (
  input  logic [NCOL*CW-1:0] col_cnt,
  output logic [2*W-1:0]     sum
);
  localparam int PW = 2 * W;
  localparam int AW = PW + CW;

  logic [AW-1:0] acc;
  logic [CW-1:0] spill;

  // Bit m of column k's count lands in column k+m.
  always_comb begin
    acc = '0;
    for (int k = 0; k < NCOL; k++) begin
      acc = acc + (AW'(col_cnt[k*CW +: CW]) << k);
    end
  end

  assign sum   = acc[PW-1:0];
  assign spill = acc[AW-1:PW];

  // Weights past the top product bit must carry nothing.
  always_comb begin
    assert_no_overflow_R4: assert (spill == '0);
  end
endmodule

// File: rtl/vcm_mul.sv
module vcm_mul #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  import vcm_pkg::*;

  localparam int PW   = 2 * W;
  localparam int NCOL = 2 * W - 1;
  localparam int CW   = $clog2(W + 1);

  logic [W*W-1:0]   pp;
  logic [NCOL*CW-1:0] col_cnt;
  logic [PW-1:0]    prod_comb;

  pp_grid #(.W(W)) u_pp (
    .op_a (op_a),
    .op_b (op_b),
    .pp   (pp)
  );

  // Stage 1: one ones-counter per column, sized to its height.
  for (genvar k = 0; k < NCOL; k++) begin : g_column
    localparam int H  = col_height(k, W);
    localparam int R0 = col_first_row(k, W);
    localparam int OW = $clog2(H + 1);

    logic [H-1:0]  bits;
    logic [OW-1:0] cnt;

    for (genvar t = 0; t < H; t++) begin : g_tap
      assign bits[t] = pp[(R0 + t) * W + (k - R0 - t)];
    end

    ones_counter #(.N(H), .OW(OW)) u_cnt (
      .bits  (bits),
      .count (cnt)
    );

    assign col_cnt[k*CW +: CW] = CW'(cnt);
  end

  // Stage 2: merge the weighted counts.
  weight_merge #(.W(W), .CW(CW), .NCOL(NCOL)) u_merge (
    .col_cnt (col_cnt),
    .sum     (prod_comb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        product   <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) product <= prod_comb;
      end
    end

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(product));
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> product == $past(prod_comb));
  end else begin : g_pass
    assign out_valid = in_valid;
    assign product   = prod_comb;
  end

  assert_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prod_comb[0] == (op_a[0] & op_b[0]));
  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == '0 || op_b == '0) |-> prod_comb == '0);
  assert_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_b == W'(1)) |-> prod_comb == PW'(op_a));
endmodule

// File: tb/tb_vcm_mul.sv
module tb_vcm_mul;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          out_valid;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcm_mul #(.W(W), .OUT_REG(1'b1)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    logic [PW-1:0] exp_prev;
    int pa, pb;
    bit have_prev;

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 out_valid in reset", 32'(out_valid), 32'd0);
    check("R8 product in reset", 32'(product), 32'd0);
    rst_n = 1'b1;

    have_prev = 1'b0;
    exp_prev  = '0;
    pa = 0; pb = 0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        if (have_prev) begin
          if (pa == 0 || pb == 0)      check("R5 zero operand", 32'(product), 32'(exp_prev));
          else if (pa == 1 || pb == 1) check("R6 unit operand", 32'(product), 32'(exp_prev));
          else                         check("R1 product", 32'(product), 32'(exp_prev));
          check("R2 bit0", 32'(product[0]), 32'((pa & pb) & 1));
          check("R7 out_valid", 32'(out_valid), 32'd1);
        end
        op_a = W'(a); op_b = W'(b); in_valid = 1'b1;
        pa = a; pb = b;
        exp_prev = PW'(a * b);
        have_prev = 1'b1;
      end
    end

    // Last pair is 255*255: every column full, top carries (R3, R4).
    @(negedge clk);
    check("R3 all columns full", 32'(product), 32'd65025);
    check("R4 top weight kept", 32'(product[15]), 32'd1);

    // R7: idle cycle, new operands must not load.
    op_a = 8'd3; op_b = 8'd5; in_valid = 1'b0;
    @(negedge clk);
    check("R7 idle out_valid", 32'(out_valid), 32'd0);
    check("R7 idle hold", 32'(product), 32'd65025);
    in_valid = 1'b1;
    @(negedge clk);
    check("R7 resume", 32'(product), 32'd15);
    check("R7 resume valid", 32'(out_valid), 32'd1);

    // R8: reset again clears the register.
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R8 reset clears", 32'(product), 32'd0);
    check("R8 reset valid", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule